// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a small set of fully associative slots. Each slot carries a virtual page tag, an 8-bit address-space number, a global flag, a physical page number, a read-enable and a write-enable mask with one bit per privilege mode, and two fault-on-access flags (read and write). A lookup is combinational on the stored state: the caller presents a page number, an address-space number and a 2-bit privilege mode. In the same cycle the block returns hit, the physical page, both masks, the two fault flags, and whether the given mode may read or write.

New translations go into the slot chosen by a replacement pointer, which moves round-robin. The current slot index and its valid flag are visible at all times. A separate strobe moves the pointer on without writing a slot.

Three invalidation commands exist. The first clears the whole array. The second drops every translation that is not global. The third drops the translations for one page that belong to a given address space, and any global translation for that page. Any flush wins over an insert in the same cycle.

Top module: `asn_tlb`

## Requirements
- R1: After synchronous reset no lookup hits, `rp_idx` is 0 and `rp_valid` is 0.
- R2: A lookup hits when a valid slot has tag equal to `lk_vpn` and either its global flag set or its stored ASN equal to `lk_asn`. It then returns that slot's PPN, masks and fault flags.
- R3: A non-global slot whose stored ASN differs from `lk_asn` does not hit, even with an equal tag.
- R4: An accepted insert writes the slot at `rp_idx`, replacing any valid content there. The stored tag is `ins_vpn` and the slot is marked valid. `rp_idx` then rises by one and wraps from ENTRIES-1 to 0.
- R5: `fl_all` invalidates every slot and sets `rp_idx` to 0.
- R6: `fl_proc` invalidates every non-global slot, keeps global slots, and does not move `rp_idx`.
- R7: `fl_addr` invalidates each slot whose tag equals `fl_vpn` and that is either global or has ASN equal to `fl_asn`. All other slots are kept.
- R8: `rp_adv` moves `rp_idx` forward by one, with wrap, and writes no slot. `rp_valid` reports the valid flag of the slot at `rp_idx`.
- R9: When a flush and an insert coincide, the insert is dropped and does not move the pointer. A lookup in the cycle of a flush sees the contents from before the flush.
- R10: If several slots match a lookup, the lowest-index slot supplies the outputs.
- R11: `lk_rd_ok` equals bit `lk_mode` of the hit slot's read mask, and `lk_wr_ok` equals bit `lk_mode` of its write mask. Both are 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 19 | Lookup virtual page number |
| lk_asn | input | 8 | Lookup address-space number |
| lk_mode | input | 2 | Current privilege mode, indexes the masks |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 16 | Physical page of the hit slot |
| lk_rd_mask | output | 4 | Read-enable mask of the hit slot |
| lk_wr_mask | output | 4 | Write-enable mask of the hit slot |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit slot |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit slot |
| lk_rd_ok | output | 1 | Read allowed in `lk_mode` |
| lk_wr_ok | output | 1 | Write allowed in `lk_mode` |
| ins_en | input | 1 | Insert strobe |
| ins_vpn | input | 19 | Tag of the new translation |
| ins_asn | input | 8 | ASN of the new translation |
| ins_global | input | 1 | Global flag of the new translation |
| ins_ppn | input | 16 | Physical page of the new translation |
| ins_rd_mask | input | 4 | Read-enable mask of the new translation |
| ins_wr_mask | input | 4 | Write-enable mask of the new translation |
| ins_fault_rd | input | 1 | Fault-on-read flag of the new translation |
| ins_fault_wr | input | 1 | Fault-on-write flag of the new translation |
| fl_all | input | 1 | Invalidate all slots |
| fl_proc | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate by page and ASN |
| fl_vpn | input | 19 | Page for `fl_addr` |
| fl_asn | input | 8 | ASN for `fl_addr` |
| rp_adv | input | 1 | Advance the replacement pointer |
| rp_idx | output | 3 | Current replacement slot |
| rp_valid | output | 1 | Valid flag of the slot at `rp_idx` |

## Verification
Lookups are run with an equal ASN, with a different ASN on a non-global slot, and with a different ASN on a global slot. These three cases separate the ASN qualification from the global override. A full wrap of the pointer followed by one more insert shows that replacement overwrites the oldest slot and that the wrap is correct. The per-address flush is run over two slots with the same page and different ASNs, over a slot in the same space but on a neighbouring page, and over a global slot. This shows that it removes only what a lookup would match. Two slots matching the same lookup, and flushes that coincide with inserts and lookups, pin down the selection order and the priorities within a cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 19;
    parameter int PPN_W  = 16;
    parameter int ASN_W  = 8;
    parameter int MODE_W = 2;
    localparam int MASK_W = 1 << MODE_W;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASN_W-1:0]  asn;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [MASK_W-1:0] rd_en;
        logic [MASK_W-1:0] wr_en;
        logic              flt_rd;
        logic              flt_wr;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        FL_NONE = 2'd0,
        FL_ADDR = 2'd1,
        FL_PROC = 2'd2,
        FL_ALL  = 2'd3
    } flush_e;

    // Flush-all outranks flush-process, which outranks flush-address.
    function automatic flush_e pick_flush(input logic all, input logic proc, input logic addr);
        if (all)       return FL_ALL;
        else if (proc) return FL_PROC;
        else if (addr) return FL_ADDR;
        else           return FL_NONE;
    endfunction

    function automatic logic mode_allows(input logic [MASK_W-1:0] mask, input logic [MODE_W-1:0] mode);
        return mask[mode];
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t             ents [ENTRIES],
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASN_W-1:0]       asn,
    output logic [ENTRIES-1:0]     hits
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hits[i] = ents[i].valid && (ents[i].vpn == vpn) &&
                         (ents[i].glob || (ents[i].asn == asn));
    end
endmodule

// File: rtl/tlb_select.sv
module tlb_select
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t         ents [ENTRIES],
    input  logic [ENTRIES-1:0] hits,
    output logic               any_hit,
    output tlb_entry_t         chosen
);
    // Scan from the top down so the lowest matching index is written last.
    always_comb begin
        chosen  = '0;
        any_hit = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                chosen  = ents[i];
                any_hit = 1'b1;
            end
        end
    end

    // R2: a reported hit always comes from a valid slot
    always_comb begin
        if (any_hit) a_r2_hit_from_valid: assert (chosen.valid);
    end
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)  ptr <= '0;
        else if (step)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    a_r5_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ptr == '0));
    a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && ptr == LAST) |=> (ptr == '0));
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  flush_e             fl_kind,
    input  logic [ENTRIES-1:0] fa_hits,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_slot,
    input  tlb_entry_t         wr_data,
    output tlb_entry_t         ents [ENTRIES],
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] glob_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else begin
                case (fl_kind)
                    FL_ALL:  ents[i] <= '0;
                    FL_PROC: if (!ents[i].glob) ents[i].valid <= 1'b0;
                    FL_ADDR: if (fa_hits[i])    ents[i].valid <= 1'b0;
                    default: if (wr_en && wr_slot == IDX_W'(i)) begin
                        ents[i]       <= wr_data;
                        ents[i].valid <= 1'b1;
                    end
                endcase
            end
        end
        assign valid_vec[i] = ents[i].valid;
        assign glob_vec[i]  = ents[i].glob;
    end

    a_r5_all_cleared: assert property (@(posedge clk) disable iff (rst)
        (fl_kind == FL_ALL) |=> (valid_vec == '0));
    a_r6_globals_kept: assert property (@(posedge clk) disable iff (rst)
        (fl_kind == FL_PROC) |=> (valid_vec == $past(valid_vec & glob_vec)));
    a_r7_addr_dropped: assert property (@(posedge clk) disable iff (rst)
        (fl_kind == FL_ADDR) |=> ((valid_vec & $past(fa_hits)) == '0));
    a_r9_no_write_on_flush: assert property (@(posedge clk) disable iff (rst)
        (fl_kind != FL_NONE) |=> ((valid_vec & ~$past(valid_vec)) == '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    input  logic [MODE_W-1:0] lk_mode,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [MASK_W-1:0] lk_rd_mask,
    output logic [MASK_W-1:0] lk_wr_mask,
    output logic              lk_fault_rd,
    output logic              lk_fault_wr,
    output logic              lk_rd_ok,
    output logic              lk_wr_ok,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [MASK_W-1:0] ins_rd_mask,
    input  logic [MASK_W-1:0] ins_wr_mask,
    input  logic              ins_fault_rd,
    input  logic              ins_fault_wr,
    input  logic              fl_all,
    input  logic              fl_proc,
    input  logic              fl_addr,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn,
    input  logic              rp_adv,
    output logic [IDX_W-1:0]  rp_idx,
    output logic              rp_valid
);
    tlb_entry_t         ents [ENTRIES];
    tlb_entry_t         new_ent;
    tlb_entry_t         sel;
    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] fa_hits;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] glob_vec;
    logic               ins_go;
    logic               any_hit;
    flush_e             fl_kind;

    assign fl_kind = pick_flush(fl_all, fl_proc, fl_addr);
    assign ins_go  = ins_en && (fl_kind == FL_NONE);

    always_comb begin
        new_ent        = '0;
        new_ent.valid  = 1'b1;
        new_ent.glob   = ins_global;
        new_ent.asn    = ins_asn;
        new_ent.vpn    = ins_vpn;
        new_ent.ppn    = ins_ppn;
        new_ent.rd_en  = ins_rd_mask;
        new_ent.wr_en  = ins_wr_mask;
        new_ent.flt_rd = ins_fault_rd;
        new_ent.flt_wr = ins_fault_wr;
    end

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .fl_kind(fl_kind), .fa_hits(fa_hits),
        .wr_en(ins_go), .wr_slot(rp_idx), .wr_data(new_ent),
        .ents(ents), .valid_vec(valid_vec), .glob_vec(glob_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents(ents), .vpn(lk_vpn), .asn(lk_asn), .hits(lk_hits)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .ents(ents), .vpn(fl_vpn), .asn(fl_asn), .hits(fa_hits)
    );

    tlb_select #(.ENTRIES(ENTRIES)) u_select (
        .ents(ents), .hits(lk_hits), .any_hit(any_hit), .chosen(sel)
    );

    tlb_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst(rst), .clear(fl_all), .step(ins_go || rp_adv), .ptr(rp_idx)
    );

    assign lk_hit      = any_hit;
    assign lk_ppn      = sel.ppn;
    assign lk_rd_mask  = sel.rd_en;
    assign lk_wr_mask  = sel.wr_en;
    assign lk_fault_rd = sel.flt_rd;
    assign lk_fault_wr = sel.flt_wr;
    assign lk_rd_ok    = any_hit && mode_allows(sel.rd_en, lk_mode);
    assign lk_wr_ok    = any_hit && mode_allows(sel.wr_en, lk_mode);
    assign rp_valid    = valid_vec[rp_idx];

    // R4: an accepted insert leaves a valid slot behind it
    a_r4_insert_lands: assert property (@(posedge clk) disable iff (rst)
        ins_go |=> valid_vec[$past(rp_idx)]);
    // R9: an insert beside a flush must not move the pointer by itself
    a_r9_flush_blocks_insert: assert property (@(posedge clk) disable iff (rst)
        (ins_en && fl_proc && !fl_all && !rp_adv) |=> $stable(rp_idx));
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [18:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic [1:0]  lk_mode;
    logic        lk_hit;
    logic [15:0] lk_ppn;
    logic [3:0]  lk_rd_mask, lk_wr_mask;
    logic        lk_fault_rd, lk_fault_wr, lk_rd_ok, lk_wr_ok;
    logic        ins_en;
    logic [18:0] ins_vpn;
    logic [7:0]  ins_asn;
    logic        ins_global;
    logic [15:0] ins_ppn;
    logic [3:0]  ins_rd_mask, ins_wr_mask;
    logic        ins_fault_rd, ins_fault_wr;
    logic        fl_all, fl_proc, fl_addr;
    logic [18:0] fl_vpn;
    logic [7:0]  fl_asn;
    logic        rp_adv;
    logic [2:0]  rp_idx;
    logic        rp_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asn_tlb u_dut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs;
        lk_vpn = '0; lk_asn = '0; lk_mode = '0;
        ins_en = 0; ins_vpn = '0; ins_asn = '0; ins_global = 0; ins_ppn = '0;
        ins_rd_mask = '0; ins_wr_mask = '0; ins_fault_rd = 0; ins_fault_wr = 0;
        fl_all = 0; fl_proc = 0; fl_addr = 0; fl_vpn = '0; fl_asn = '0; rp_adv = 0;
    endtask

    task automatic set_ins(input logic [18:0] v, input logic [7:0] a, input logic g, input logic [15:0] p);
        ins_en = 1; ins_vpn = v; ins_asn = a; ins_global = g; ins_ppn = p;
        ins_rd_mask = 4'b1111; ins_wr_mask = 4'b1111; ins_fault_rd = 0; ins_fault_wr = 0;
    endtask

    task automatic insert(input logic [18:0] v, input logic [7:0] a, input logic g, input logic [15:0] p);
        set_ins(v, a, g, p);
        tick;
        ins_en = 0;
    endtask

    task automatic flush_all_now;
        fl_all = 1; tick; fl_all = 0;
    endtask

    task automatic look(input string req, input logic [18:0] v, input logic [7:0] a,
                        input logic exp_hit, input logic [15:0] exp_ppn);
        lk_vpn = v; lk_asn = a;
        #1;
        chk(req, "hit", 32'(lk_hit), 32'(exp_hit));
        if (exp_hit) chk(req, "ppn", 32'(lk_ppn), 32'(exp_ppn));
    endtask

    task automatic t_reset;
        rst = 1; idle_inputs(); tick; tick; rst = 0; #1;
        look("R1", 19'h0, 8'h0, 0, 0);
        chk("R1", "rp_idx", 32'(rp_idx), 0);
        chk("R1", "rp_valid", 32'(rp_valid), 0);
    endtask

    task automatic t_basic;
        flush_all_now();
        set_ins(19'h10, 8'd3, 0, 16'h111);
        ins_rd_mask = 4'b0011; ins_wr_mask = 4'b0001; ins_fault_wr = 1;
        tick; ins_en = 0;
        lk_mode = 2'd1;
        look("R2", 19'h10, 8'd3, 1, 16'h111);
        chk("R2", "rd_mask", 32'(lk_rd_mask), 32'h3);
        chk("R2", "wr_mask", 32'(lk_wr_mask), 32'h1);
        chk("R2", "fault_rd", 32'(lk_fault_rd), 0);
        chk("R2", "fault_wr", 32'(lk_fault_wr), 1);
        chk("R11", "rd_ok mode1", 32'(lk_rd_ok), 1);
        chk("R11", "wr_ok mode1", 32'(lk_wr_ok), 0);
        lk_mode = 2'd0; #1;
        chk("R11", "wr_ok mode0", 32'(lk_wr_ok), 1);
        lk_mode = 2'd3; #1;
        chk("R11", "rd_ok mode3", 32'(lk_rd_ok), 0);
        look("R3", 19'h10, 8'd4, 0, 0);
        chk("R11", "rd_ok on miss", 32'(lk_rd_ok), 0);
        insert(19'h20, 8'd5, 1, 16'h222);
        look("R2", 19'h20, 8'd9, 1, 16'h222);
        look("R2", 19'h21, 8'd5, 0, 0);
    endtask

    task automatic t_wrap;
        flush_all_now();
        for (int i = 0; i < 8; i++) insert(19'(32'h100 + i), 8'd1, 0, 16'(32'h500 + i));
        chk("R4", "rp_idx after wrap", 32'(rp_idx), 0);
        chk("R4", "rp_valid full", 32'(rp_valid), 1);
        look("R4", 19'h107, 8'd1, 1, 16'h507);
        insert(19'h200, 8'd1, 0, 16'h600);
        look("R4", 19'h100, 8'd1, 0, 0);
        look("R4", 19'h200, 8'd1, 1, 16'h600);
        look("R4", 19'h101, 8'd1, 1, 16'h501);
        chk("R4", "rp_idx after overwrite", 32'(rp_idx), 1);
    endtask

    task automatic t_adv;
        flush_all_now();
        chk("R5", "rp_idx after flush", 32'(rp_idx), 0);
        look("R5", 19'h101, 8'd1, 0, 0);
        rp_adv = 1; tick; rp_adv = 0;
        chk("R8", "rp_idx after adv", 32'(rp_idx), 1);
        chk("R8", "rp_valid empty", 32'(rp_valid), 0);
        insert(19'h33, 8'd2, 0, 16'h333);
        chk("R8", "rp_idx after ins", 32'(rp_idx), 2);
        rp_adv = 1; tick; tick; tick; tick; tick; tick; rp_adv = 0;
        chk("R8", "rp_idx wrapped", 32'(rp_idx), 0);
        chk("R8", "rp_valid slot0 empty", 32'(rp_valid), 0);
        rp_adv = 1; tick; rp_adv = 0;
        chk("R8", "rp_valid slot1", 32'(rp_valid), 1);
    endtask

    task automatic t_proc;
        flush_all_now();
        insert(19'h30, 8'd1, 0, 16'h30);
        insert(19'h31, 8'd1, 1, 16'h31);
        fl_proc = 1; tick; fl_proc = 0;
        look("R6", 19'h30, 8'd1, 0, 0);
        look("R6", 19'h31, 8'd1, 1, 16'h31);
        chk("R6", "rp_idx unchanged", 32'(rp_idx), 2);
    endtask

    task automatic t_faddr;
        flush_all_now();
        insert(19'h40, 8'd1, 0, 16'hC);
        insert(19'h40, 8'd2, 0, 16'hD);
        insert(19'h41, 8'd1, 0, 16'hE);
        insert(19'h42, 8'd7, 1, 16'hF);
        fl_addr = 1; fl_vpn = 19'h40; fl_asn = 8'd1; tick; fl_addr = 0;
        look("R7", 19'h40, 8'd1, 0, 0);
        look("R7", 19'h40, 8'd2, 1, 16'hD);
        look("R7", 19'h41, 8'd1, 1, 16'hE);
        fl_addr = 1; fl_vpn = 19'h42; fl_asn = 8'd3; tick; fl_addr = 0;
        look("R7", 19'h42, 8'd7, 0, 0);
        chk("R7", "rp_idx unchanged", 32'(rp_idx), 4);
    endtask

    task automatic t_prio;
        flush_all_now();
        insert(19'h60, 8'd1, 1, 16'h60);
        set_ins(19'h61, 8'd1, 1, 16'h61);
        fl_proc = 1; tick; ins_en = 0; fl_proc = 0;
        look("R9", 19'h61, 8'd1, 0, 0);
        chk("R9", "rp_idx after blocked ins", 32'(rp_idx), 1);
        lk_vpn = 19'h60; lk_asn = 8'd1; fl_all = 1; #1;
        chk("R9", "hit during flush cycle", 32'(lk_hit), 1);
        tick; fl_all = 0;
        look("R9", 19'h60, 8'd1, 0, 0);
    endtask

    task automatic t_multi;
        flush_all_now();
        insert(19'h50, 8'd1, 0, 16'hA);
        insert(19'h50, 8'd1, 1, 16'hB);
        look("R10", 19'h50, 8'd1, 1, 16'hA);
        look("R10", 19'h50, 8'd2, 1, 16'hB);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_adv();
        t_proc();
        t_faddr();
        t_prio();
        t_multi();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule